// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers a word of level-sensitive interrupt sources and presents them to a processor as two request lines. A normal request line (`irq_o`) and a fast request line (`fiq_o`) each have their own enable mask. Both masks look at the same captured source word. Each output is high while at least one enabled source is active.

Software reaches the block through a simple word-addressed register port. The port gives per-output masked status, the raw source word, and enable masks with separate set and clear addresses. It also has a software-driven source that shares source position 0 with the hardware input at that position. Read data and the error flag come back registered, one cycle after the access. The error flag marks accesses that go the wrong way on a one-direction register, and accesses to unused offsets.

Controllers can be chained: the request output of one can be wired to a source input of another. The block does no prioritisation and no vector generation.

Top module: `dual_mask_intc`

## Requirements
- R1: On every clock edge outside reset, source bits 1 and above are captured from `src_i` into the raw word. The raw word reads back at word offset 1 and also at word offset 9.
- R2: Raw bit 0 is the OR of `src_i[0]` and a software bit. Any write to offset 4 sets the software bit, whatever the data. Any write to offset 5 clears it, whatever the data. A read of offset 4 returns the software bit in bit 0 and zeros elsewhere.
- R3: A read of offset 0 returns raw AND normal-mask. A read of offset 8 returns raw AND fast-mask.
- R4: A write to offset 2 (normal) or 10 (fast) ORs the data into that mask. A write to offset 3 (normal) or 11 (fast) clears the mask bits where the data is 1. Reads of offsets 2 and 10 return the current masks.
- R5: The two masks are independent: a write to one mask's set or clear offset leaves the other mask unchanged.
- R6: `irq_o` is high exactly when the offset-0 status is nonzero. `fiq_o` is high exactly when the offset-8 status is nonzero. Both follow a mask write in the cycle after the write.
- R7: Writes to offsets 0, 1, 8 and 9 change no state and pulse `cfg_err` in the following cycle.
- R8: Reads of offsets 3, 5 and 11 return zero and pulse `cfg_err` in the following cycle.
- R9: Offsets not listed above (6, 7, 12 to 15) read as zero, ignore writes, and pulse `cfg_err`.
- R10: Reset clears both masks, the software bit and the raw word, so both outputs are low.
- R11: `cfg_rdata` and `cfg_err` are registered, valid in the cycle after the access, and `cfg_err` falls again after a clean access. A change on `src_i` reaches the outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Level-sensitive interrupt sources |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | ADDR_W | Word offset of the access |
| cfg_wdata | input | NSRC | Write data |
| cfg_rdata | output | NSRC | Read data, registered |
| cfg_err | output | 1 | Access error pulse, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The masking path is driven with source words that:
- hit only normal-enabled bits,
- hit only fast-enabled bits,
- hit bits enabled in both masks,
- hit bits enabled in neither mask.

Together these show whether the two masks are really separate and whether each output reduces only its own status. Set and clear writes are overlapped on the same mask, to tell an OR-merge apart from an overwrite. Source position 0 is exercised with the hardware input and the software bit active together, to show that clearing one does not hide the other. Wrong-direction and unused offsets are accessed while the masks hold nonzero values, so any aliasing onto a live register shows up as changed read data.

// File: rtl/dmi_pkg.sv
package dmi_pkg;

  localparam logic [3:0] OFS_IRQ_STAT = 4'd0;
  localparam logic [3:0] OFS_IRQ_RAW  = 4'd1;
  localparam logic [3:0] OFS_IRQ_ENS  = 4'd2;
  localparam logic [3:0] OFS_IRQ_ENC  = 4'd3;
  localparam logic [3:0] OFS_SW_SET   = 4'd4;
  localparam logic [3:0] OFS_SW_CLR   = 4'd5;
  localparam logic [3:0] OFS_FIQ_STAT = 4'd8;
  localparam logic [3:0] OFS_FIQ_RAW  = 4'd9;
  localparam logic [3:0] OFS_FIQ_ENS  = 4'd10;
  localparam logic [3:0] OFS_FIQ_ENC  = 4'd11;

  localparam int NUM_OUT = 2;
  localparam int OUT_IRQ = 0;
  localparam int OUT_FIQ = 1;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_IRQ_STAT,
    RS_RAW,
    RS_IRQ_MASK,
    RS_SW,
    RS_FIQ_STAT,
    RS_FIQ_MASK
  } rd_sel_e;

  typedef struct packed {
    logic [NUM_OUT-1:0] mask_set;
    logic [NUM_OUT-1:0] mask_clr;
    logic               sw_set;
    logic               sw_clr;
    logic               bad;
  } wr_dec_t;

endpackage

// File: rtl/dmi_decode.sv
module dmi_decode
  import dmi_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output wr_dec_t           wdec,
  output rd_sel_e           rsel,
  output logic              rd_bad
);

  logic       hi_zero;
  logic [3:0] lo;

  assign lo = addr[3:0];

  generate
    if (ADDR_W > 4) begin : g_hi
      assign hi_zero = ~|addr[ADDR_W-1:4];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    wdec   = '0;
    rsel   = RS_ZERO;
    rd_bad = 1'b0;
    if (!hi_zero) begin
      wdec.bad = 1'b1;
      rd_bad   = 1'b1;
    end else begin
      case (lo)
        OFS_IRQ_STAT: begin rsel = RS_IRQ_STAT; wdec.bad = 1'b1; end
        OFS_IRQ_RAW:  begin rsel = RS_RAW;      wdec.bad = 1'b1; end
        OFS_FIQ_STAT: begin rsel = RS_FIQ_STAT; wdec.bad = 1'b1; end
        OFS_FIQ_RAW:  begin rsel = RS_RAW;      wdec.bad = 1'b1; end
        OFS_IRQ_ENS:  begin rsel = RS_IRQ_MASK; wdec.mask_set[OUT_IRQ] = 1'b1; end
        OFS_FIQ_ENS:  begin rsel = RS_FIQ_MASK; wdec.mask_set[OUT_FIQ] = 1'b1; end
        OFS_IRQ_ENC:  begin rd_bad = 1'b1; wdec.mask_clr[OUT_IRQ] = 1'b1; end
        OFS_FIQ_ENC:  begin rd_bad = 1'b1; wdec.mask_clr[OUT_FIQ] = 1'b1; end
        OFS_SW_SET:   begin rsel = RS_SW; wdec.sw_set = 1'b1; end
        OFS_SW_CLR:   begin rd_bad = 1'b1; wdec.sw_clr = 1'b1; end
        default:      begin rd_bad = 1'b1; wdec.bad = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/dmi_src_capture.sv
module dmi_src_capture #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            sw_set,
  input  logic            sw_clr,
  output logic [NSRC-1:0] raw_o,
  output logic            sw_o
);

  logic [NSRC-1:0] cap_q;
  logic            sw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      sw_q  <= 1'b0;
    end else begin
      cap_q <= src_i;
      if (sw_set)      sw_q <= 1'b1;
      else if (sw_clr) sw_q <= 1'b0;
    end
  end

  assign raw_o = {cap_q[NSRC-1:1], cap_q[0] | sw_q};
  assign sw_o  = sw_q;

endmodule

// File: rtl/dmi_mask_reg.sv
module dmi_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_o
);

  always_ff @(posedge clk) begin
    if (rst)         mask_o <= '0;
    else if (set_en) mask_o <= mask_o | wdata;
    else if (clr_en) mask_o <= mask_o & ~wdata;
  end

endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc
  import dmi_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [NSRC-1:0]   cfg_wdata,
  output logic [NSRC-1:0]   cfg_rdata,
  output logic              cfg_err,
  output logic              irq_o,
  output logic              fiq_o
);

  wr_dec_t dec_w;
  rd_sel_e rsel_w;
  logic    rd_bad_w;

  logic [NSRC-1:0]               raw_w;
  logic                          sw_w;
  logic [NUM_OUT-1:0][NSRC-1:0]  mask_w;
  logic [NUM_OUT-1:0][NSRC-1:0]  stat_w;

  dmi_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr   (cfg_addr),
    .wdec   (dec_w),
    .rsel   (rsel_w),
    .rd_bad (rd_bad_w)
  );

  dmi_src_capture #(.NSRC(NSRC)) cap_i (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src_i),
    .sw_set (cfg_wr_en & dec_w.sw_set),
    .sw_clr (cfg_wr_en & dec_w.sw_clr),
    .raw_o  (raw_w),
    .sw_o   (sw_w)
  );

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_mask
      dmi_mask_reg #(.W(NSRC)) mask_i (
        .clk    (clk),
        .rst    (rst),
        .set_en (cfg_wr_en & dec_w.mask_set[g]),
        .clr_en (cfg_wr_en & dec_w.mask_clr[g]),
        .wdata  (cfg_wdata),
        .mask_o (mask_w[g])
      );
      assign stat_w[g] = raw_w & mask_w[g];
    end
  endgenerate

  assign irq_o = |stat_w[OUT_IRQ];
  assign fiq_o = |stat_w[OUT_FIQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err <= (cfg_wr_en & dec_w.bad) | (cfg_rd_en & rd_bad_w);
      if (cfg_rd_en) begin
        case (rsel_w)
          RS_IRQ_STAT: cfg_rdata <= stat_w[OUT_IRQ];
          RS_FIQ_STAT: cfg_rdata <= stat_w[OUT_FIQ];
          RS_RAW:      cfg_rdata <= raw_w;
          RS_IRQ_MASK: cfg_rdata <= mask_w[OUT_IRQ];
          RS_FIQ_MASK: cfg_rdata <= mask_w[OUT_FIQ];
          RS_SW:       cfg_rdata <= {{(NSRC-1){1'b0}}, sw_w};
          default:     cfg_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/dmi_checker.sv
module dmi_checker #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_i,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic [NSRC-1:0]   rdata,
  input logic              err,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   raw,
  input logic              sw,
  input logic [NSRC-1:0]   mask_irq,
  input logic [NSRC-1:0]   mask_fiq
);

  // R1: upper raw bits equal the sources of the previous edge
  p_raw_track_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (raw[NSRC-1:1] == $past(src_i[NSRC-1:1])));

  // R4: set-write leaves every written bit set in the normal mask
  p_irq_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(2)) |=> ((mask_irq & $past(wdata)) == $past(wdata)));

  // R4: clear-write removes every written bit from the fast mask
  p_fiq_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(11)) |=> ((mask_fiq & $past(wdata)) == '0));

  // R5: writing the normal mask does not touch the fast mask
  p_mask_indep_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(2) || addr == ADDR_W'(3))) |=> $stable(mask_fiq));

  // R7: writes to status/raw offsets change nothing and flag an error
  p_ro_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(0) || addr == ADDR_W'(1) ||
               addr == ADDR_W'(8) || addr == ADDR_W'(9)))
    |=> ($stable(mask_irq) && $stable(mask_fiq) && $stable(sw) && err));

  // R8: reads of write-only offsets return zero and flag an error
  p_wo_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == ADDR_W'(3) || addr == ADDR_W'(5) || addr == ADDR_W'(11)))
    |=> (rdata == '0 && err));

  // R10: first cycle after reset shows cleared state and quiet outputs
  p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_irq == '0 && mask_fiq == '0 && !sw && !irq_o && !fiq_o));

endmodule

bind dual_mask_intc dmi_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .src_i    (src_i),
  .wr_en    (cfg_wr_en),
  .rd_en    (cfg_rd_en),
  .addr     (cfg_addr),
  .wdata    (cfg_wdata),
  .rdata    (cfg_rdata),
  .err      (cfg_err),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .raw      (raw_w),
  .sw       (sw_w),
  .mask_irq (mask_w[0]),
  .mask_fiq (mask_w[1])
);

// File: tb/dual_mask_intc_tb_top.sv
`timescale 1ns/1ps
module dual_mask_intc_tb_top;

  localparam int NSRC   = 32;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSRC-1:0]   src_i = '0;
  logic              cfg_wr_en = 1'b0;
  logic              cfg_rd_en = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [NSRC-1:0]   cfg_wdata = '0;
  logic [NSRC-1:0]   cfg_rdata;
  logic              cfg_err;
  logic              irq_o;
  logic              fiq_o;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dual_mask_intc #(.NSRC(NSRC), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .src_i(src_i),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_wr(input int a, input logic [31:0] d, output logic e);
    cfg_wr_en = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = d;
    @(negedge clk);
    e = cfg_err;
    cfg_wr_en = 1'b0; cfg_wdata = '0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d, output logic e);
    cfg_rd_en = 1'b1; cfg_addr = ADDR_W'(a);
    @(negedge clk);
    d = cfg_rdata; e = cfg_err;
    cfg_rd_en = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] v);
    src_i = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    check("R10", "irq_o after reset", 32'(irq_o), 0);
    check("R10", "fiq_o after reset", 32'(fiq_o), 0);
    bus_rd(2, d, e);  check("R10", "normal mask", d, 0);
    bus_rd(10, d, e); check("R10", "fast mask", d, 0);
    bus_rd(4, d, e);  check("R10", "soft bit", d, 0);
    check("R11", "err after clean read", 32'(e), 0);
  endtask

  task automatic t_raw;
    logic [31:0] d; logic e;
    set_src(32'hA5A5_0F0E);
    bus_rd(1, d, e); check("R1", "raw at 1", d, 32'hA5A5_0F0E);
    bus_rd(9, d, e); check("R1", "raw at 9", d, 32'hA5A5_0F0E);
    set_src(32'h8000_0002);
    bus_rd(1, d, e); check("R1", "raw after change", d, 32'h8000_0002);
    set_src(32'h0);
  endtask

  task automatic t_soft;
    logic [31:0] d; logic e;
    bus_wr(4, 32'h0, e);
    bus_rd(1, d, e); check("R2", "raw bit0 from soft set", d, 32'h1);
    bus_rd(4, d, e); check("R2", "soft bit readback", d, 32'h1);
    set_src(32'h1);
    bus_wr(5, 32'h0, e);
    bus_rd(1, d, e); check("R2", "hw bit0 survives soft clear", d, 32'h1);
    bus_rd(4, d, e); check("R2", "soft bit cleared", d, 32'h0);
    set_src(32'h0);
    bus_rd(1, d, e); check("R2", "bit0 low with both off", d, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d; logic e;
    bus_wr(2, 32'h0000_00F0, e);
    bus_wr(2, 32'h0F00_0000, e);
    bus_rd(2, d, e);  check("R4", "normal mask OR-merge", d, 32'h0F00_00F0);
    bus_rd(10, d, e); check("R5", "fast mask untouched", d, 32'h0);
    bus_wr(3, 32'h0000_0030, e);
    bus_rd(2, d, e);  check("R4", "normal mask clear", d, 32'h0F00_00C0);
    bus_wr(10, 32'hFFFF_0000, e);
    bus_wr(11, 32'h00FF_0000, e);
    bus_rd(10, d, e); check("R4", "fast mask set/clear", d, 32'hFF00_0000);
    bus_rd(2, d, e);  check("R5", "normal mask untouched", d, 32'h0F00_00C0);
  endtask

  task automatic t_status;
    logic [31:0] d; logic e;
    set_src(32'h0100_0040);
    bus_rd(0, d, e); check("R3", "normal status both-enabled", d, 32'h0100_0040);
    bus_rd(8, d, e); check("R3", "fast status both-enabled", d, 32'h0100_0000);
    check("R6", "irq_o both", 32'(irq_o), 1);
    check("R6", "fiq_o both", 32'(fiq_o), 1);
    set_src(32'h0000_0100);
    bus_rd(0, d, e); check("R3", "normal status none enabled", d, 0);
    check("R6", "irq_o none", 32'(irq_o), 0);
    check("R6", "fiq_o none", 32'(fiq_o), 0);
    set_src(32'h8000_0000);
    check("R6", "irq_o fast-only", 32'(irq_o), 0);
    check("R6", "fiq_o fast-only", 32'(fiq_o), 1);
    bus_wr(11, 32'h8000_0000, e);
    check("R6", "fiq_o after mask clear", 32'(fiq_o), 0);
    bus_wr(10, 32'h8000_0000, e);
    set_src(32'h0000_0080);
    check("R6", "irq_o normal-only", 32'(irq_o), 1);
    check("R6", "fiq_o normal-only", 32'(fiq_o), 0);
    set_src(32'h0);
  endtask

  task automatic t_readonly;
    logic [31:0] d; logic e;
    bus_wr(0, 32'hFFFF_FFFF, e); check("R7", "err write 0", 32'(e), 1);
    bus_wr(1, 32'hFFFF_FFFF, e); check("R7", "err write 1", 32'(e), 1);
    bus_wr(8, 32'hFFFF_FFFF, e); check("R7", "err write 8", 32'(e), 1);
    bus_wr(9, 32'hFFFF_FFFF, e); check("R7", "err write 9", 32'(e), 1);
    bus_rd(2, d, e);  check("R7", "normal mask kept", d, 32'h0F00_00C0);
    bus_rd(10, d, e); check("R7", "fast mask kept", d, 32'hFF00_0000);
    bus_rd(1, d, e);  check("R7", "raw kept", d, 32'h0);
    check("R7", "irq_o still low", 32'(irq_o), 0);
  endtask

  task automatic t_writeonly;
    logic [31:0] d; logic e;
    bus_rd(3, d, e);  check("R8", "read 3 data", d, 0);  check("R8", "read 3 err", 32'(e), 1);
    bus_rd(5, d, e);  check("R8", "read 5 data", d, 0);  check("R8", "read 5 err", 32'(e), 1);
    bus_rd(11, d, e); check("R8", "read 11 data", d, 0); check("R8", "read 11 err", 32'(e), 1);
    @(negedge clk);
    check("R11", "err falls after idle cycle", 32'(cfg_err), 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    bus_wr(7, 32'hFFFF_FFFF, e);  check("R9", "write 7 err", 32'(e), 1);
    bus_wr(14, 32'hFFFF_FFFF, e); check("R9", "write 14 err", 32'(e), 1);
    bus_rd(6, d, e);  check("R9", "read 6 data", d, 0); check("R9", "read 6 err", 32'(e), 1);
    bus_rd(15, d, e); check("R9", "read 15 data", d, 0);
    bus_rd(2, d, e);  check("R9", "normal mask kept", d, 32'h0F00_00C0);
    check("R11", "clean read err low", 32'(e), 0);
    bus_rd(4, d, e);  check("R9", "soft bit kept", d, 0);
  endtask

  task automatic t_latency;
    src_i = 32'h0000_0040;
    #1;
    check("R11", "irq_o before edge", 32'(irq_o), 0);
    @(negedge clk);
    check("R11", "irq_o after one edge", 32'(irq_o), 1);
    set_src(32'h0);
    check("R11", "irq_o falls after one edge", 32'(irq_o), 0);
  endtask

  task automatic t_midreset;
    logic [31:0] d; logic e;
    bus_wr(4, 32'h0, e);
    set_src(32'h0100_0000);
    check("R10", "fiq_o before reset", 32'(fiq_o), 1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    src_i = '0;
    @(negedge clk);
    bus_rd(2, d, e);  check("R10", "normal mask after reset", d, 0);
    bus_rd(10, d, e); check("R10", "fast mask after reset", d, 0);
    bus_rd(4, d, e);  check("R10", "soft bit after reset", d, 0);
    check("R10", "outputs low", 32'({irq_o, fiq_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_raw();
    t_soft();
    t_mask();
    t_status();
    t_readonly();
    t_writeonly();
    t_unmapped();
    t_latency();
    t_midreset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule